// File: doc/BRIEF.md
# Two-Wire Bus Slave with Byte Queues and Status Flags

This block is the target side of a two-wire serial bus (I2C, 7-bit addressing). It watches the clock and data lines through synchronising flip-flops and recognises START and STOP. It compares each address byte against four programmable identities and acknowledges a match. Written bytes go into a small receive queue. Bytes for a read are taken from a small transmit queue. The data line is only ever pulled low, through `sda_oe`. The block does not stretch the clock.

A host uses a register port of eight byte-wide locations. Offset 0 reads the head of the receive queue, and reading it pops that byte. Offset 1 pushes a byte into the transmit queue. Offset 2 is status. Offset 3 is control: bit 0 enables the receive interrupt, bit 1 enables the transmit interrupt, and bit 2 selects early-transmit timing. Offsets 4 to 7 hold the four identities.

The status byte carries four flags. Bit 0 is receive-request, bit 1 is transmit-request, bit 2 is underflow and bit 3 is early-transmit. Each flag follows its own timing rule, tied to the SCL edges of the R/W bit. Setting the control bits routes the receive and transmit requests to `irq`.

Top module: `i2c_slave_fifo`

## Requirements
- R1: START (SDA falls while SCL is high) restarts address reception, and STOP (SDA rises while SCL is high) returns the block to idle. A STOP in the middle of a byte releases SDA, and the next transfer is handled normally.
- R2: The address byte is compared against bits [6:0] of the four identity registers (offsets 4 to 7); bit 7 of an identity plays no part. On a match the block pulls SDA low during the ninth clock. With no match it leaves SDA released and stores nothing.
- R3: In a write transfer, data bytes are shifted in MSB first on rising SCL, queued and acknowledged. A byte that arrives while the receive queue is full is dropped and not acknowledged.
- R4: In a read transfer, bytes from the transmit queue are driven MSB first, changing after falling SCL. An empty queue yields 0xFF. A master NACK ends the read.
- R5: Status bit 0 is high exactly while the receive queue holds a byte. A host read of offset 0 pops one byte, and offset 0 reads 0x00 when the queue is empty.
- R6: Status bit 1 rises on an address match with R/W = 1. If control bit 2 = 0 it rises after the falling SCL edge of the R/W bit; if control bit 2 = 1 it rises after the rising edge. It clears on START or STOP.
- R7: Status bit 2 sets at the rising SCL edge of the R/W bit of a matched read while the transmit queue is empty. It clears on START or STOP.
- R8: If control bit 2 = 0, status bit 3 equals "transmit queue empty". If control bit 2 = 1, it sets at the rising SCL edge of the R/W bit of a matched write, at most once between START/STOP events, and a host read of offset 2 clears it.
- R9: `irq` = (control bit 0 AND status bit 0) OR (control bit 1 AND status bit 1).
- R10: Each queue holds two bytes. A push to offset 1 while the transmit queue is full is ignored.
- R11: A one-cycle pulse on `flush_tx` or `flush_rx` empties the matching queue.
- R12: After reset the identity and control registers read 0x00, offset 0 reads 0x00, offset 1 reads 0x00, and status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when high |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (pops queue / clears flag) |
| addr | input | 3 | Host register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr` |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit count or a wrong state shows up on the bus within one byte time. The acknowledge then lands on the wrong clock, or a read byte comes back shifted. Errors in a queue pointer or count show up at the register port on the next host access, as a wrong head byte or a wrong status bit 0. A wrong flag edge shows up as a status value that differs between the rising and the falling phase of the R/W bit, and the bench samples both phases.

// File: rtl/i2c_slave_fifo.sv
module i2c_slave_fifo #(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       flush_tx,
  input  logic       flush_rx,
  output logic       irq
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_DACK, S_TX, S_MACK} st_t;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // line synchronisers and edge events
  logic [2:0] scl_s, sda_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  logic sda_v, scl_rise, scl_fall, start_c, stop_c;
  assign sda_v    = sda_s[1];
  assign scl_rise = scl_s[1] & ~scl_s[2];
  assign scl_fall = ~scl_s[1] & scl_s[2];
  assign start_c  = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  assign stop_c   = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];

  // host registers
  logic [7:0] ids [4];
  logic [2:0] ctrl;
  logic       rx_ie, tx_ie, early_en;
  assign {early_en, tx_ie, rx_ie} = ctrl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      for (int i = 0; i < 4; i++) ids[i] <= '0;
    end else if (wr_en) begin
      if (addr == 3'd3) ctrl <= wdata[2:0];
      if (addr[2]) ids[addr[1:0]] <= wdata;
    end

  // state
  st_t        state;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic       drv, ph, nak, rw;
  logic       tx_req, uflow, early_q, early_done;

  // transmit queue
  logic [7:0]    txm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_push, tx_pop, tx_empty, load;
  logic [7:0]    tx_byte;

  assign tx_empty = (tx_cnt == '0);
  assign tx_push  = wr_en && addr == 3'd1 && tx_cnt != FULL;
  assign load     = scl_fall && ((state == S_AACK && ph && rw) || state == S_MACK);
  assign tx_pop   = load && !tx_empty;
  assign tx_byte  = tx_empty ? 8'hFF : txm[tx_rp];

  always_ff @(posedge clk)
    if (tx_push) txm[tx_wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (flush_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  // receive queue
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_push, rx_pop, rx_any;

  assign rx_any  = (rx_cnt != '0);
  assign rx_pop  = rd_en && addr == 3'd0 && rx_any;
  assign rx_push = state == S_RX && scl_rise && cnt == 3'd7 && rx_cnt != FULL;

  always_ff @(posedge clk)
    if (rx_push) rxm[rx_wp] <= {sh[6:0], sda_v};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (flush_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // address compare
  logic [3:0] hit_v;
  logic       addr_hit, rw_edge, early_set, stat_rd;
  for (genvar g = 0; g < 4; g++) begin : g_cmp
    assign hit_v[g] = (ids[g][6:0] == sh[6:0]);
  end
  assign addr_hit  = |hit_v;
  assign rw_edge   = state == S_ADDR && scl_rise && cnt == 3'd7 && addr_hit;
  assign early_set = rw_edge && !sda_v && early_en && !early_done;
  assign stat_rd   = rd_en && addr == 3'd2;

  // bus state machine
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0;
      drv <= 1'b0; ph <= 1'b0; nak <= 1'b0; rw <= 1'b0;
      tx_req <= 1'b0; uflow <= 1'b0;
    end else if (start_c || stop_c) begin
      state  <= start_c ? S_ADDR : S_IDLE;
      cnt    <= '0;
      drv    <= 1'b0;
      ph     <= 1'b0;
      tx_req <= 1'b0;
      uflow  <= 1'b0;
    end else begin
      case (state)
        S_ADDR: if (scl_rise) begin
          sh  <= {sh[6:0], sda_v};
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (addr_hit) begin
              state <= S_AACK;
              rw    <= sda_v;
              nak   <= 1'b0;
              if (sda_v && early_en) tx_req <= 1'b1;
              if (sda_v && tx_empty) uflow  <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (!ph) begin
            ph  <= 1'b1;
            drv <= 1'b1;
            if (rw && !early_en) tx_req <= 1'b1;
          end else begin
            ph  <= 1'b0;
            cnt <= '0;
            if (rw) begin
              sh    <= tx_byte;
              drv   <= ~tx_byte[7];
              state <= S_TX;
            end else begin
              drv   <= 1'b0;
              state <= S_RX;
            end
          end
        end
        S_RX: if (scl_rise) begin
          sh  <= {sh[6:0], sda_v};
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            nak   <= (rx_cnt == FULL);
            state <= S_DACK;
          end
        end
        S_DACK: if (scl_fall) begin
          if (!ph) begin
            ph  <= 1'b1;
            drv <= ~nak;
          end else begin
            ph    <= 1'b0;
            drv   <= 1'b0;
            cnt   <= '0;
            state <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            drv   <= 1'b0;
            state <= S_MACK;
          end else begin
            sh  <= {sh[6:0], 1'b0};
            drv <= ~sh[6];
          end
        end
        S_MACK: begin
          if (scl_rise && sda_v) begin
            state <= S_IDLE;
          end else if (scl_fall) begin
            sh    <= tx_byte;
            drv   <= ~tx_byte[7];
            cnt   <= '0;
            state <= S_TX;
          end
        end
        default: ;
      endcase
    end

  // early-transmit flag
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      early_q    <= 1'b0;
      early_done <= 1'b0;
    end else begin
      if (start_c || stop_c) early_done <= 1'b0;
      else if (early_set)    early_done <= 1'b1;
      if (early_set)         early_q <= 1'b1;
      else if (stat_rd)      early_q <= 1'b0;
    end

  // outputs
  logic [7:0] status;
  assign status = {4'b0, (early_en ? early_q : tx_empty), uflow, tx_req, rx_any};
  assign sda_oe = drv;
  assign irq    = (rx_ie & rx_any) | (tx_ie & tx_req);

  always_comb begin
    case (addr)
      3'd0:    rdata = rx_any ? rxm[rx_rp] : 8'h00;
      3'd2:    rdata = status;
      3'd3:    rdata = {5'b0, ctrl};
      3'd4, 3'd5, 3'd6, 3'd7: rdata = ids[addr[1:0]];
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_slave_fifo_chk.sv
module i2c_slave_fifo_chk #(
  parameter int DEPTH = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_c,
  input logic          sda_oe,
  input logic          tx_req,
  input logic          uflow,
  input logic          irq,
  input logic [2:0]    ctrl,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    addr,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_push,
  input logic          tx_pop,
  input logic          flush_tx,
  input logic          flush_rx
);
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && !tx_req && !uflow)); // R1

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b00) |-> !irq); // R9

  AST_TX_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && tx_cnt == CW'(DEPTH) && !tx_pop && !flush_tx)
      |=> tx_cnt == CW'(DEPTH)); // R10

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH))); // R10

  AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx |=> tx_cnt == '0); // R11

  AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx |=> rx_cnt == '0); // R11

  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0 && rx_cnt == CW'(1) && !rx_push && !flush_rx)
      |=> rx_cnt == '0); // R5
endmodule

bind i2c_slave_fifo i2c_slave_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_c(stop_c), .sda_oe(sda_oe),
  .tx_req(tx_req), .uflow(uflow), .irq(irq), .ctrl(ctrl),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_push(rx_push), .tx_pop(tx_pop),
  .flush_tx(flush_tx), .flush_rx(flush_rx)
);

// File: tb/sim_i2c_slave_fifo.sv
module sim_i2c_slave_fifo;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line, irq, wr_en = 1'b0, rd_en = 1'b0;
  logic flush_tx = 1'b0, flush_rx = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_fifo u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .flush_tx(flush_tx), .flush_rx(flush_rx), .irq(irq));

  // {wr, rd, addr, data, expected}
  localparam logic [20:0] VEC [13] = '{
    {1'b0, 1'b1, 3'd2, 8'h00, 8'h08},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h00},
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 1'b1, 3'd5, 8'h00, 8'h00},
    {1'b1, 1'b0, 3'd4, 8'h12, 8'h00},
    {1'b1, 1'b0, 3'd6, 8'hD5, 8'h00},
    {1'b0, 1'b1, 3'd4, 8'h00, 8'h12},
    {1'b0, 1'b1, 3'd6, 8'h00, 8'hD5},
    {1'b0, 1'b1, 3'd7, 8'h00, 8'h00},
    {1'b1, 1'b0, 3'd3, 8'h05, 8'h00},
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h05},
    {1'b1, 1'b0, 3'd3, 8'h00, 8'h00},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic mstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic mstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic mbit_w(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic mbit_r(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(Q/2); b = sda_line; wq(Q/2); scl_m = 1'b0; wq();
  endtask

  task automatic mbyte_w(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) mbit_w(d[i]);
    mbit_r(ack);
  endtask

  task automatic mbyte_r(input logic ackb, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) mbit_r(d[i]);
    mbit_w(ackb);
  endtask

  // START, seven address bits, then R/W = 1 up to the high phase
  task automatic to_rw_high(input logic [6:0] a);
    mstart();
    for (int i = 6; i >= 0; i--) mbit_w(a[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic ack;
    wq(4); rst_n = 1'b1; wq(4);
    check("R12 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    check("R12 irq after reset", {7'b0, irq}, 8'h00);

    for (int k = 0; k < 13; k++) begin
      if (VEC[k][20]) hwrite(VEC[k][18:16], VEC[k][15:8]);
      if (VEC[k][19]) begin
        hread(VEC[k][18:16], d);
        check($sformatf("R12/R2 table entry %0d", k), d, VEC[k][7:0]);
      end
    end

    // R1: STOP in the middle of an address
    mstart(); mbit_w(1'b0); mbit_w(1'b0); mbit_w(1'b1); mstop();
    check("R1 SDA released after mid-byte STOP", {7'b0, sda_oe}, 8'h00);

    // R2/R3: write transfer to 0x12, third byte overflows
    mstart();
    mbyte_w(8'h24, ack); check("R2 address ACK", {7'b0, ack}, 8'h00);
    mbyte_w(8'hA5, ack); check("R3 data ACK 1", {7'b0, ack}, 8'h00);
    mbyte_w(8'h3C, ack); check("R3 data ACK 2", {7'b0, ack}, 8'h00);
    mbyte_w(8'h77, ack); check("R3 full queue NACK", {7'b0, ack}, 8'h01);
    mstop();
    hread(3'd2, d); check("R5 rx request set", d, 8'h09);
    hwrite(3'd3, 8'h01); wq(2);
    check("R9 irq from rx request", {7'b0, irq}, 8'h01);
    hread(3'd0, d); check("R3 first byte", d, 8'hA5);
    hread(3'd0, d); check("R3 second byte", d, 8'h3C);
    hread(3'd2, d); check("R5 rx request cleared", d, 8'h08);
    check("R9 irq drops", {7'b0, irq}, 8'h00);
    hread(3'd0, d); check("R5 empty queue reads zero", d, 8'h00);

    // R2: address that matches nothing
    mstart(); mbyte_w(8'h60, ack); mstop();
    check("R2 no ACK on mismatch", {7'b0, ack}, 8'h01);
    hread(3'd2, d); check("R2 nothing stored", d, 8'h08);

    // R8: early mode on a write, identity bit 7 ignored
    hwrite(3'd3, 8'h04); hread(3'd2, d);
    check("R8 early flag idle in mode 1", d, 8'h00);
    mstart();
    mbyte_w(8'hAA, ack); check("R2 match ignores identity bit 7", {7'b0, ack}, 8'h00);
    hread(3'd2, d); check("R8 early flag set on write", d, 8'h08);
    hread(3'd2, d); check("R8 early flag cleared by read", d, 8'h00);
    mbyte_w(8'h11, ack);
    hread(3'd2, d); check("R8 early flag once per transfer", d, 8'h01);
    mstop();
    @(negedge clk); flush_rx = 1'b1; @(negedge clk); flush_rx = 1'b0;
    hread(3'd2, d); check("R11 rx flush", d, 8'h00);

    // R6/R4/R10: read with normal timing
    hwrite(3'd3, 8'h02);
    hwrite(3'd1, 8'hC3); hwrite(3'd1, 8'h5A); hwrite(3'd1, 8'hEE);
    hread(3'd2, d); check("R8 mode 0 tracks non-empty queue", d, 8'h00);
    to_rw_high(7'h12);
    hread(3'd2, d); check("R6 no request at rising edge (mode 0)", d, 8'h00);
    scl_m = 1'b0; wq();
    hread(3'd2, d); check("R6 request after falling edge", d, 8'h02);
    check("R9 irq from tx request", {7'b0, irq}, 8'h01);
    mbit_r(ack); check("R2 read address ACK", {7'b0, ack}, 8'h00);
    mbyte_r(1'b0, d); check("R4 first read byte", d, 8'hC3);
    mbyte_r(1'b0, d); check("R10 second byte, third push ignored", d, 8'h5A);
    mbyte_r(1'b1, d); check("R4 empty queue gives FF", d, 8'hFF);
    mstop();
    hread(3'd2, d); check("R6 request cleared by STOP", d, 8'h08);
    check("R9 irq drops after STOP", {7'b0, irq}, 8'h00);

    // R6/R7: early timing on an empty queue
    hwrite(3'd3, 8'h04); hread(3'd2, d);
    to_rw_high(7'h12);
    hread(3'd2, d); check("R7 underflow and early request at rising edge", d, 8'h06);
    scl_m = 1'b0; wq();
    mbit_r(ack);
    mbyte_r(1'b1, d); check("R4 underflow byte", d, 8'hFF);
    mstop();
    hread(3'd2, d); check("R7 underflow cleared by STOP", d, 8'h00);

    // R11: transmit flush
    hwrite(3'd3, 8'h00);
    hwrite(3'd1, 8'h11); hwrite(3'd1, 8'h22);
    hread(3'd2, d); check("R8 queue not empty", d, 8'h00);
    @(negedge clk); flush_tx = 1'b1; @(negedge clk); flush_tx = 1'b0;
    hread(3'd2, d); check("R11 tx flush", d, 8'h08);

    finish_run();
  end
endmodule